// File: doc/BRIEF.md
# Masked Breakpoint Address Comparator

This block watches a CPU bus and flags one access at a time. It raises a one-clock match pulse when the current access hits an address that software has programmed. Each access carries a logical address, a page number and a flag that says whether a paged program window is being accessed. It also carries a read strobe and a valid strobe. When the access is paged, the compare covers the page number plus the offset bits inside the window. When the access is not paged, the compare covers the full logical address.

Two mask bits choose how much of the address takes part. With the low mask clear, the whole address is compared. With only the low mask set, the low byte is dropped from the compare. With both masks set, only the page number is compared, so any access into that expansion page matches. The combination "high masked, low compared" makes no sense, so the hardware treats it as a full compare. A direction qualifier can restrict matches to reads only or to writes only.

The compare registers are loaded through a small write port. With the default parameter setting, the port is byte-wide and addressed. The other setting turns it into a single wide port that loads every field in one write.

Top module: `bkpt_addr_match`

## Requirements
- R1: After reset every compare, mask and qualifier register is zero and the comparator is disabled (control bit 0 = 0), so no access matches. Once the comparator is enabled with everything else still zero, any access to address 0 matches whatever its direction.
- R2: In byte-port mode a write places its data in one register, chosen by the write address. Address 0 is the control register: bit 0 enable, bit 1 high mask, bit 2 low mask, bit 3 direction enable, bit 4 direction value. Address 1 is the page (low 6 bits), address 2 the high byte and address 3 the low byte. Writes to addresses 4 to 7 change nothing.
- R3: The match output is registered. It goes high for exactly one clock, in the cycle after a valid access that meets every enabled condition. It stays low for cycles with valid low and while the enable bit is 0.
- R4: Full compare on a paged access checks 20 bits: the page input against the page register, and address bits [13:0] against {high[5:0], low}. Address bits [15:14] are ignored.
- R5: Full compare on a non-paged access checks address [15:0] against {high, low}. The page input is ignored.
- R6: The mask setting high=1, low=0 gives exactly the same result as a full compare.
- R7: The mask setting high=0, low=1 ignores the low address byte. It compares address [13:8] against high[5:0] together with the page on a paged access, and address [15:8] against high on a non-paged access.
- R8: The mask setting high=1, low=1 matches any paged access whose page equals the page register. It never matches a non-paged access.
- R9: With direction enable 0, reads and writes match alike, whatever the direction value bit holds.
- R10: With direction enable 1, a direction value of 1 matches only reads (read strobe 1) and a value of 0 matches only writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register select (byte-port mode) |
| cfg_data_i | input | WD_W (8) | Write data: one byte, or {ctrl, page, high, low} in wide mode |
| bus_valid_i | input | 1 | Bus access valid this cycle |
| bus_rd_i | input | 1 | 1 = read access, 0 = write access |
| bus_paged_i | input | 1 | Access falls in the paged program window |
| bus_page_i | input | PAGE_W (6) | Page number of the access |
| bus_addr_i | input | 2*BYTE_W (16) | Logical CPU address |
| match_o | output | 1 | Registered one-cycle match pulse |

## Verification
The in-line assertions check four properties on every cycle. A pulse always follows a valid, enabled access. A page-only match always follows a paged access. A direction-qualified match always has the right strobe. Writes to unused register addresses leave the configuration untouched. Only the bench scenarios can show that the compare covers the right bits in each of the four mask settings, in both paged and non-paged form. They also cover ignoring address bits [15:14] in the paged window, the forced full compare, and the reset-state compare against address zero. The scoreboard predicts each access from the requirements and checks the pulse one clock later.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  // register select codes (byte-port mode)
  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_PAGE = 3'd1;
  localparam logic [2:0] RA_HIGH = 3'd2;
  localparam logic [2:0] RA_LOW  = 3'd3;

  // control register bit positions
  localparam int unsigned CB_EN    = 0;
  localparam int unsigned CB_HMASK = 1;
  localparam int unsigned CB_LMASK = 2;
  localparam int unsigned CB_RWEN  = 3;
  localparam int unsigned CB_RWRD  = 4;
  localparam int unsigned CTRL_W   = 5;

  typedef enum logic [1:0] {
    CMP_FULL = 2'd0,
    CMP_HIGH = 2'd1,
    CMP_PAGE = 2'd2
  } cmp_mode_e;

  // low mask clear selects a full compare whatever the high mask says
  function automatic cmp_mode_e mode_of(input logic hmask, input logic lmask);
    if (!lmask)     return CMP_FULL;
    else if (!hmask) return CMP_HIGH;
    else            return CMP_PAGE;
  endfunction

endpackage

// File: rtl/bkpt_cfg_regs.sv
module bkpt_cfg_regs
  import bkpt_pkg::*;
#(
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned PAGE_W   = 6,
  parameter bit          REG_PORT = 1'b1,
  parameter int unsigned WD_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [2:0]        addr_i,
  input  logic [WD_W-1:0]   data_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [BYTE_W-1:0] high_o,
  output logic [BYTE_W-1:0] low_o
);

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic [BYTE_W-1:0] high_q, high_d;
  logic [BYTE_W-1:0] low_q,  low_d;
  logic              load;

  generate
    if (REG_PORT) begin : g_byte_port
      always_comb begin
        ctrl_d = ctrl_q;
        page_d = page_q;
        high_d = high_q;
        low_d  = low_q;
        load   = 1'b0;
        if (wr_i) begin
          unique case (addr_i)
            RA_CTRL: begin ctrl_d = data_i[CTRL_W-1:0]; load = 1'b1; end
            RA_PAGE: begin page_d = data_i[PAGE_W-1:0]; load = 1'b1; end
            RA_HIGH: begin high_d = data_i[BYTE_W-1:0]; load = 1'b1; end
            RA_LOW:  begin low_d  = data_i[BYTE_W-1:0]; load = 1'b1; end
            default: load = 1'b0;
          endcase
        end
      end

      // R2: unused register addresses leave all state untouched
      a_r2_unused_addr_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && (addr_i > RA_LOW)) |=>
          ($stable(ctrl_q) && $stable(page_q) && $stable(high_q) && $stable(low_q)))
        else $error("a_r2_unused_addr_ignored");
    end else begin : g_wide_port
      always_comb begin
        load = wr_i;
        {ctrl_d, page_d, high_d, low_d} = {ctrl_q, page_q, high_q, low_q};
        if (wr_i) {ctrl_d, page_d, high_d, low_d} = data_i;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      page_q <= '0;
      high_q <= '0;
      low_q  <= '0;
    end else if (load) begin
      ctrl_q <= ctrl_d;
      page_q <= page_d;
      high_q <= high_d;
      low_q  <= low_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign page_o = page_q;
  assign high_o = high_q;
  assign low_o  = low_q;

endmodule

// File: rtl/bkpt_addr_cmp.sv
module bkpt_addr_cmp
  import bkpt_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned PAGE_W = 6,
  parameter int unsigned OFF_W  = 14
) (
  input  cmp_mode_e           mode_i,
  input  logic [PAGE_W-1:0]   ref_page_i,
  input  logic [BYTE_W-1:0]   ref_high_i,
  input  logic [BYTE_W-1:0]   ref_low_i,
  input  logic                paged_i,
  input  logic [PAGE_W-1:0]   page_i,
  input  logic [2*BYTE_W-1:0] addr_i,
  output logic                hit_o
);

  localparam int unsigned ADDR_W = 2 * BYTE_W;
  localparam int unsigned HOFF_W = OFF_W - BYTE_W;

  logic page_eq, low_eq, hi_win_eq, hi_lin_eq;

  always_comb begin
    page_eq   = (page_i == ref_page_i);
    low_eq    = (addr_i[BYTE_W-1:0] == ref_low_i);
    hi_win_eq = (addr_i[OFF_W-1:BYTE_W] == ref_high_i[HOFF_W-1:0]);
    hi_lin_eq = (addr_i[ADDR_W-1:BYTE_W] == ref_high_i);
  end

  always_comb begin
    hit_o = 1'b0;
    unique case (mode_i)
      CMP_FULL: hit_o = paged_i ? (page_eq && hi_win_eq && low_eq)
                                : (hi_lin_eq && low_eq);
      CMP_HIGH: hit_o = paged_i ? (page_eq && hi_win_eq) : hi_lin_eq;
      CMP_PAGE: hit_o = paged_i && page_eq;
      default:  hit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/bkpt_addr_match.sv
module bkpt_addr_match
  import bkpt_pkg::*;
#(
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned PAGE_W   = 6,
  parameter int unsigned OFF_W    = 14,
  parameter bit          REG_PORT = 1'b1,
  localparam int unsigned ADDR_W  = 2 * BYTE_W,
  localparam int unsigned WD_W    = REG_PORT ? BYTE_W : (CTRL_W + PAGE_W + 2 * BYTE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [2:0]        cfg_addr_i,
  input  logic [WD_W-1:0]   cfg_data_i,
  input  logic              bus_valid_i,
  input  logic              bus_rd_i,
  input  logic              bus_paged_i,
  input  logic [PAGE_W-1:0] bus_page_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  output logic              match_o
);

  logic [CTRL_W-1:0] ctrl;
  logic [PAGE_W-1:0] ref_page;
  logic [BYTE_W-1:0] ref_high, ref_low;
  cmp_mode_e         mode;
  logic              addr_hit, dir_ok, match_d, match_q;

  bkpt_cfg_regs #(
    .BYTE_W(BYTE_W), .PAGE_W(PAGE_W), .REG_PORT(REG_PORT), .WD_W(WD_W)
  ) cfg_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_i  (cfg_wr_i),
    .addr_i(cfg_addr_i),
    .data_i(cfg_data_i),
    .ctrl_o(ctrl),
    .page_o(ref_page),
    .high_o(ref_high),
    .low_o (ref_low)
  );

  assign mode = mode_of(ctrl[CB_HMASK], ctrl[CB_LMASK]);

  bkpt_addr_cmp #(
    .BYTE_W(BYTE_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W)
  ) cmp_i (
    .mode_i    (mode),
    .ref_page_i(ref_page),
    .ref_high_i(ref_high),
    .ref_low_i (ref_low),
    .paged_i   (bus_paged_i),
    .page_i    (bus_page_i),
    .addr_i    (bus_addr_i),
    .hit_o     (addr_hit)
  );

  always_comb begin
    dir_ok  = !ctrl[CB_RWEN] || (bus_rd_i == ctrl[CB_RWRD]);
    match_d = ctrl[CB_EN] && bus_valid_i && addr_hit && dir_ok;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) match_q <= 1'b0;
    else         match_q <= match_d;
  end

  assign match_o = match_q;

  // R3: a pulse is always preceded by a valid access
  a_r3_pulse_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> $past(bus_valid_i))
    else $error("a_r3_pulse_needs_valid");

  // R3: no pulse follows a cycle with the comparator disabled
  a_r3_disabled_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl[CB_EN] |=> !match_o)
    else $error("a_r3_disabled_silent");

  // R8: page-only matches come from paged accesses with equal page
  a_r8_page_only_paged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && $past(ctrl[CB_HMASK] && ctrl[CB_LMASK])) |->
      ($past(bus_paged_i) && ($past(bus_page_i) == $past(ref_page))))
    else $error("a_r8_page_only_paged");

  // R10: a direction-qualified pulse has the selected direction
  a_r10_direction_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && $past(ctrl[CB_RWEN])) |-> ($past(bus_rd_i) == $past(ctrl[CB_RWRD])))
    else $error("a_r10_direction_kept");

  // R1: output low while reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_ni) a_r1_reset_low: assert (match_o == 1'b0) else $error("a_r1_reset_low");
  end

endmodule

// File: tb/bkpt_addr_match_tb_top.sv
`timescale 1ns/1ps
module bkpt_addr_match_tb_top;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PAGE_W = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [2:0]  cfg_addr;
  logic [7:0]  cfg_data;
  logic        bus_valid, bus_rd, bus_paged;
  logic [5:0]  bus_page;
  logic [15:0] bus_addr;
  logic        match;

  always #10 clk = ~clk;  // 50 MHz

  bkpt_addr_match dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_wr_i(cfg_wr), .cfg_addr_i(cfg_addr), .cfg_data_i(cfg_data),
    .bus_valid_i(bus_valid), .bus_rd_i(bus_rd), .bus_paged_i(bus_paged),
    .bus_page_i(bus_page), .bus_addr_i(bus_addr), .match_o(match)
  );

  typedef struct {
    logic        exp;
    string       tag;
    logic [15:0] addr;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench mirror of the programmed state
  logic [4:0] m_ctrl;
  logic [5:0] m_page;
  logic [7:0] m_high, m_low;

  function automatic logic predict(logic v, logic rd, logic pg, logic [5:0] p, logic [15:0] a);
    logic addr_ok, dir_ok;
    if (!v || !m_ctrl[0]) return 1'b0;
    dir_ok = !m_ctrl[3] || (rd == m_ctrl[4]);
    if (!m_ctrl[2])                         // full compare (covers forced 1:0)
      addr_ok = pg ? (p == m_page && a[13:0] == {m_high[5:0], m_low})
                   : (a == {m_high, m_low});
    else if (!m_ctrl[1])                    // low byte masked
      addr_ok = pg ? (p == m_page && a[13:8] == m_high[5:0]) : (a[15:8] == m_high);
    else                                    // page only
      addr_ok = pg && (p == m_page);
    return addr_ok && dir_ok;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b0;
    cfg_wr = 1'b1; cfg_addr = a; cfg_data = d;
    case (a)
      3'd0: m_ctrl = d[4:0];
      3'd1: m_page = d[5:0];
      3'd2: m_high = d;
      3'd3: m_low  = d;
      default: ;
    endcase
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic acc(input string tag, input logic v, input logic rd, input logic pg,
                     input logic [5:0] p, input logic [15:0] a);
    item_t it;
    @(negedge clk);
    cfg_wr = 1'b0;
    bus_valid = v; bus_rd = rd; bus_paged = pg; bus_page = p; bus_addr = a;
    it.exp = predict(v, rd, pg, p, a); it.tag = tag; it.addr = a;
    q.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  // monitor: compare one expected item per cycle
  initial begin
    forever begin
      @(posedge clk); #5;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (match !== it.exp) begin
          errors++;
          $display("FAIL %s addr=%h match actual=%b expected=%b", it.tag, it.addr, match, it.exp);
        end
      end
    end
  end

  initial begin
    #(20ns * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_data = '0;
    bus_valid = 1'b0; bus_rd = 1'b0; bus_paged = 1'b0; bus_page = '0; bus_addr = '0;
    m_ctrl = '0; m_page = '0; m_high = '0; m_low = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (match !== 1'b0) begin
      errors++; $display("FAIL R1 reset actual=%b expected=0", match);
    end
    rst_n = 1'b1;

    // R1: disabled after reset, then zero compare with direction ignored
    acc("R1", 1, 1, 0, 6'h00, 16'h0000);
    wr(3'd0, 8'h01);
    acc("R1", 1, 1, 0, 6'h00, 16'h0000);
    acc("R1", 1, 0, 0, 6'h00, 16'h0000);
    acc("R1", 1, 0, 0, 6'h00, 16'h0001);

    wr(3'd1, 8'h2B); wr(3'd2, 8'h9C); wr(3'd3, 8'h3E);
    // R5: non-paged full compare
    acc("R5", 1, 1, 0, 6'h00, 16'h9C3E);
    acc("R5", 1, 1, 0, 6'h11, 16'h9C3E);
    acc("R5", 1, 1, 0, 6'h2B, 16'h9C3F);
    acc("R5", 1, 1, 0, 6'h2B, 16'h1C3E);
    // R4: paged full compare, bits [15:14] ignored
    acc("R4", 1, 0, 1, 6'h2B, 16'h1C3E);
    acc("R4", 1, 0, 1, 6'h2B, 16'hDC3E);
    acc("R4", 1, 0, 1, 6'h2A, 16'h1C3E);
    acc("R4", 1, 0, 1, 6'h2B, 16'h1C3F);
    // R3: one pulse per access, none without valid
    acc("R3", 1, 1, 0, 6'h00, 16'h9C3E);
    acc("R3", 1, 1, 0, 6'h00, 16'h9C3E);
    acc("R3", 0, 1, 0, 6'h00, 16'h9C3E);
    acc("R3", 0, 1, 0, 6'h00, 16'h9C3E);
    // R2: unused register addresses change nothing
    wr(3'd6, 8'hFF); wr(3'd4, 8'h00); wr(3'd7, 8'hFF);
    acc("R2", 1, 1, 0, 6'h00, 16'h9C3E);
    acc("R2", 1, 1, 0, 6'h00, 16'h9C00);

    // R7: low byte masked
    wr(3'd0, 8'h05);
    acc("R7", 1, 1, 0, 6'h00, 16'h9C00);
    acc("R7", 1, 1, 0, 6'h00, 16'h9CFF);
    acc("R7", 1, 1, 0, 6'h00, 16'h9D3E);
    acc("R7", 1, 1, 1, 6'h2B, 16'h1C77);
    acc("R7", 1, 1, 1, 6'h2C, 16'h1C3E);
    acc("R7", 1, 1, 1, 6'h2B, 16'h1D3E);

    // R6: 1:0 forced to full compare
    wr(3'd0, 8'h03);
    acc("R6", 1, 1, 0, 6'h00, 16'h9C3E);
    acc("R6", 1, 1, 0, 6'h00, 16'h003E);
    acc("R6", 1, 1, 0, 6'h00, 16'h9C00);
    acc("R6", 1, 1, 1, 6'h2B, 16'h1C3E);
    acc("R6", 1, 1, 1, 6'h2A, 16'h1C3E);
    acc("R6", 1, 1, 1, 6'h2B, 16'h1C00);

    // R8: page only
    wr(3'd0, 8'h07);
    acc("R8", 1, 1, 1, 6'h2B, 16'h0000);
    acc("R8", 1, 0, 1, 6'h2B, 16'h3FFF);
    acc("R8", 1, 1, 1, 6'h2A, 16'h1C3E);
    acc("R8", 1, 1, 0, 6'h2B, 16'h9C3E);
    acc("R8", 1, 1, 0, 6'h00, 16'h9C3E);

    // R9: direction ignored, value bit set
    wr(3'd0, 8'h11);
    acc("R9", 1, 0, 0, 6'h00, 16'h9C3E);
    acc("R9", 1, 1, 0, 6'h00, 16'h9C3E);
    // R10: read only, then write only
    wr(3'd0, 8'h19);
    acc("R10", 1, 1, 0, 6'h00, 16'h9C3E);
    acc("R10", 1, 0, 0, 6'h00, 16'h9C3E);
    wr(3'd0, 8'h09);
    acc("R10", 1, 0, 1, 6'h2B, 16'h1C3E);
    acc("R10", 1, 1, 1, 6'h2B, 16'h1C3E);
    // R3: disabling stops matches
    wr(3'd0, 8'h00);
    acc("R3", 1, 0, 0, 6'h00, 16'h9C3E);

    idle();
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule